// File: doc/BRIEF.md
# Single-Wire Consumer-Control Bus Frame Receiver

This block listens to a single-wire, open-drain consumer-control bus and turns the bus waveform into received bytes. It runs directly from the slow sampling clock fs (about 32.768 kHz), so one clock cycle equals one sampling tick. The line passes through a two-flop synchroniser. A free-running tick counter is restarted on every falling edge of the line. Every timing rule is a comparison of that counter against fixed bases plus small signed trims taken from input pins.

A frame opens with a long start pulse. After it comes a sequence of 10-bit blocks. Each block holds eight data bits (most significant first), an end-of-message bit and an acknowledge slot. The first block is the header, and its low nibble carries the destination address. In the acknowledge slot the receiver pulls the line low when a response is due. It always responds to the header. It responds to a data block only when the destination matches its logical address and acknowledges are enabled. A bit period that falls outside the programmed limits raises an error pulse. The frame is then dropped and the receiver hunts for a new start pulse.

Top module: `cec_rx`

## Requirements
- R1: A start pulse is accepted only if the line stays low for 115 to 128 ticks and the next falling edge follows 141 to 154 ticks after the first. Any other pulse is ignored: no byte strobe and no error.
- R2: Each bit is decided when the counter reaches 34 + 2*dat_trim_i ticks after the bit's falling edge. dat_trim_i is a signed 3-bit value from -3 to +3. A low line gives 0 and a high line gives 1. A low phase of exactly that many ticks reads as 1, and one tick longer reads as 0.
- R3: Inside a frame, err_o pulses for one cycle when a falling edge comes fewer than 67 + min_trim_i ticks after the previous one. It also pulses when no falling edge has come by 91 + max_trim_i ticks. min_trim_i and max_trim_i are signed 3-bit values from -4 to +3. Periods of exactly 67 + min_trim_i and 90 + max_trim_i ticks are accepted.
- R4: After an error the frame is discarded. No further byte strobe or pull-down occurs until a new valid start pulse, after which reception works normally.
- R5: A block is 8 data bits sent MSB first, then the end-of-message bit, then the acknowledge bit. byte_vld_o pulses for one cycle, with the byte on byte_o, at the decision point of the 8th data bit.
- R6: In the acknowledge slot of the header block, pd_o is asserted whatever ack_dis_i is set to.
- R7: In the acknowledge slot of a data block, pd_o is asserted only if header bits [3:0] equal log_addr_i and ack_dis_i is 0.
- R8: A pull-down begins on the cycle after the acknowledge bit's falling edge is detected. It lasts exactly 49 cycles.
- R9: At the decision point of the acknowledge bit of a block whose end-of-message bit is 1, eom_o pulses for one cycle and the receiver goes idle. eom_o, err_o and byte_vld_o are never high together.
- R10: While reset is active and right after it, pd_o, err_o, eom_o and byte_vld_o are 0.
- R11: If the acknowledge bit's falling edge itself breaks the period limits, the error wins and no pull-down is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock fs, one tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Bus line level (asynchronous) |
| dat_trim_i | input | 3 | Signed decision-point trim, units of 2 ticks |
| min_trim_i | input | 3 | Signed minimum-period trim, units of 1 tick |
| max_trim_i | input | 3 | Signed maximum-period trim, units of 1 tick |
| ack_dis_i | input | 1 | Suppress acknowledge of data blocks |
| log_addr_i | input | 4 | Own logical address |
| byte_o | output | 8 | Last received byte |
| byte_vld_o | output | 1 | One-cycle strobe for byte_o |
| eom_o | output | 1 | One-cycle end-of-message pulse |
| err_o | output | 1 | One-cycle reception error pulse |
| pd_o | output | 1 | Line pull-down enable |

## Verification
The period check and the start of the acknowledge pull-down are both evaluated on the same falling edge of the acknowledge bit. The bench shortens the end-of-message bit to one tick below the minimum, so the acknowledge edge arrives early. It then expects a single error pulse and zero pull-down cycles. A second overlap occurs when a falling edge lands exactly one tick past the maximum, where the edge and the timeout fall on the same cycle. The trim sweeps place an edge there for every max_trim_i value and expect one error each time.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/cec_rx_sync.sv
module cec_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o,
  output logic rise_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign line_o = s2_q;
  assign fall_o = prev_q & ~s2_q;
  assign rise_o = ~prev_q & s2_q;
endmodule

// File: rtl/cec_rx_timer.sv
module cec_rx_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (restart_i)      cnt_o <= CW'(1);
    else if (cnt_o != SAT)   cnt_o <= cnt_o + CW'(1);
  end
endmodule

// File: rtl/cec_rx_pulldown.sv
module cec_rx_pulldown #(
  parameter int TICKS = 49
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic pd_o
);
  localparam int TW = $clog2(TICKS + 1);
  logic [TW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (cancel_i)        left_q <= '0;
    else if (start_i)         left_q <= TW'(TICKS);
    else if (left_q != '0)    left_q <= left_q - TW'(1);
  end

  assign pd_o = (left_q != '0);
endmodule

// File: rtl/cec_rx.sv
module cec_rx
  import cec_rx_pkg::*;
#(
  parameter int CW         = 8,
  parameter int DW         = 8,
  parameter int AW         = 4,
  parameter int DEC_BASE   = 34,
  parameter int MIN_BASE   = 67,
  parameter int MAX_BASE   = 90,
  parameter int ST_LO_MIN  = 115,
  parameter int ST_LO_MAX  = 128,
  parameter int ST_TOT_MIN = 141,
  parameter int ST_TOT_MAX = 154,
  parameter int ACK_TICKS  = 49
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic signed [2:0] dat_trim_i,
  input  logic signed [2:0] min_trim_i,
  input  logic signed [2:0] max_trim_i,
  input  logic              ack_dis_i,
  input  logic [AW-1:0]     log_addr_i,
  output logic [DW-1:0]     byte_o,
  output logic              byte_vld_o,
  output logic              eom_o,
  output logic              err_o,
  output logic              pd_o
);
  localparam int IW = $clog2(DW + 2);
  localparam logic [IW-1:0] LAST_DATA = IW'(DW - 1);
  localparam logic [IW-1:0] EOM_IDX   = IW'(DW);
  localparam logic [IW-1:0] ACK_IDX   = IW'(DW + 1);
  localparam logic [CW-1:0] LO_MIN  = CW'(ST_LO_MIN);
  localparam logic [CW-1:0] LO_MAX  = CW'(ST_LO_MAX);
  localparam logic [CW-1:0] TOT_MIN = CW'(ST_TOT_MIN);
  localparam logic [CW-1:0] TOT_MAX = CW'(ST_TOT_MAX);

  logic line_s, line_fall, line_rise;
  logic [CW-1:0] cnt;
  logic [CW-1:0] dec_lim, min_lim, max_lim;

  rx_state_e     state_q;
  logic          low_ok_q, first_blk_q, addr_hit_q, eom_bit_q;
  logic [IW-1:0] bit_idx_q;
  logic [DW-2:0] shreg_q;
  logic          need_ack, err_now, ack_go;

  cec_rx_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .line_o(line_s),
    .fall_o(line_fall),
    .rise_o(line_rise)
  );

  cec_rx_timer #(.CW(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(line_fall),
    .cnt_o    (cnt)
  );

  cec_rx_pulldown #(.TICKS(ACK_TICKS)) u_pd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ack_go),
    .cancel_i(err_now),
    .pd_o    (pd_o)
  );

  assign dec_lim = CW'(DEC_BASE + 2 * int'(dat_trim_i));
  assign min_lim = CW'(MIN_BASE + int'(min_trim_i));
  assign max_lim = CW'(MAX_BASE + int'(max_trim_i));

  assign need_ack = first_blk_q | (addr_hit_q & ~ack_dis_i);

  // an edge beyond max counts as timeout, so edge and timeout never disagree
  always_comb begin
    err_now = 1'b0;
    ack_go  = 1'b0;
    if (state_q == ST_BITS) begin
      if ((cnt > max_lim) || (line_fall && (cnt < min_lim))) err_now = 1'b1;
      else if (line_fall && (bit_idx_q == ACK_IDX) && need_ack) ack_go = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      low_ok_q    <= 1'b0;
      first_blk_q <= 1'b0;
      addr_hit_q  <= 1'b0;
      eom_bit_q   <= 1'b0;
      bit_idx_q   <= '0;
      shreg_q     <= '0;
      byte_o      <= '0;
      byte_vld_o  <= 1'b0;
      eom_o       <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      eom_o      <= 1'b0;
      err_o      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (line_fall) begin
            state_q  <= ST_START;
            low_ok_q <= 1'b0;
          end
        end
        ST_START: begin
          if (line_fall) begin
            if (low_ok_q && (cnt >= TOT_MIN) && (cnt <= TOT_MAX)) begin
              state_q     <= ST_BITS;
              bit_idx_q   <= '0;
              first_blk_q <= 1'b1;
              addr_hit_q  <= 1'b0;
            end else begin
              low_ok_q <= 1'b0;  // this edge opens a new candidate
            end
          end else if (cnt > TOT_MAX) begin
            state_q <= ST_IDLE;
          end else if (line_rise) begin
            low_ok_q <= (cnt >= LO_MIN) && (cnt <= LO_MAX);
          end
        end
        ST_BITS: begin
          if (err_now) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (!line_fall && (cnt == dec_lim)) begin
            if (bit_idx_q == ACK_IDX) begin
              if (eom_bit_q) begin
                eom_o   <= 1'b1;
                state_q <= ST_IDLE;
              end
              first_blk_q <= 1'b0;
              bit_idx_q   <= '0;
            end else begin
              bit_idx_q <= bit_idx_q + IW'(1);
              if (bit_idx_q == EOM_IDX) begin
                eom_bit_q <= line_s;
              end else begin
                shreg_q <= {shreg_q[DW-3:0], line_s};
                if (bit_idx_q == LAST_DATA) begin
                  byte_o     <= {shreg_q, line_s};
                  byte_vld_o <= 1'b1;
                  if (first_blk_q)
                    addr_hit_q <= ({shreg_q[AW-2:0], line_s} == log_addr_i);
                end
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cec_rx_chk.sv
module cec_rx_chk #(
  parameter int ACK_TICKS = 49
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fall_i,
  input logic pd_i,
  input logic byte_vld_i,
  input logic eom_i,
  input logic err_i
);
  int unsigned pd_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pd_run_q <= 0;
    else if (pd_i) pd_run_q <= pd_run_q + 1;
    else           pd_run_q <= 0;
  end

  assert_pd_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |-> (pd_run_q < ACK_TICKS));

  assert_pd_after_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_i) |-> $past(fall_i));

  assert_err_beats_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !pd_i);

  assert_no_pd_after_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (!pd_i && !byte_vld_i));

  assert_flags_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_vld_i, eom_i, err_i}));

  assert_err_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i);
endmodule

bind cec_rx cec_rx_chk #(.ACK_TICKS(ACK_TICKS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fall_i    (line_fall),
  .pd_i      (pd_o),
  .byte_vld_i(byte_vld_o),
  .eom_i     (eom_o),
  .err_i     (err_o)
);

// File: tb/tb_cec_rx.sv
module tb_cec_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv = 1'b1;
  logic signed [2:0] dat_trim = '0, min_trim = '0, max_trim = '0;
  logic ack_dis = 1'b0;
  logic [3:0] log_addr = 4'h5;
  logic [7:0] byte_w;
  logic byte_vld, eom, err, pd;
  wire line = drv & ~pd;

  int checks = 0, errors = 0;
  int nbytes = 0, neom = 0, nerr = 0, pd_total = 0, pd_run = 0, pd_last = 0;
  logic [7:0] bytes_q [0:255];
  int lo0 = 60, lo1 = 20;

  always #5 clk = ~clk;

  cec_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .dat_trim_i(dat_trim), .min_trim_i(min_trim), .max_trim_i(max_trim),
    .ack_dis_i(ack_dis), .log_addr_i(log_addr),
    .byte_o(byte_w), .byte_vld_o(byte_vld), .eom_o(eom), .err_o(err), .pd_o(pd)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld) begin bytes_q[nbytes[7:0]] = byte_w; nbytes++; end
      if (eom) neom++;
      if (err) nerr++;
      if (pd) begin pd_run++; pd_total++; end
      else if (pd_run != 0) begin pd_last = pd_run; pd_run = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bit_slot(input bit v, input int p, output bit pd_mid);
    int l;
    l = v ? lo1 : lo0;
    pd_mid = 1'b0;
    for (int t = 0; t < p; t++) begin
      drv = (t < l) ? 1'b0 : 1'b1;
      if (t == 30) pd_mid = pd;
      @(negedge clk);
    end
  endtask

  task automatic send_start(input int lo, input int tot);
    for (int t = 0; t < tot; t++) begin
      drv = (t < lo) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic send_block(input logic [7:0] b, input bit e, input int pidx,
                            input int pval, output bit ack);
    bit v, m;
    ack = 1'b0;
    for (int i = 0; i < 10; i++) begin
      v = (i < 8) ? b[7-i] : ((i == 8) ? e : 1'b1);
      bit_slot(v, (i == pidx) ? pval : 80, m);
      if (i == 9) ack = m;
    end
  endtask

  task automatic idle_gap();
    drv = 1'b1;
    repeat (200) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a0, a1;
    int b0, e0, r0, p0;
    repeat (3) @(negedge clk);
    check(pd == 0 && err == 0 && eom == 0 && byte_vld == 0, "R10 in reset", pd, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pd == 0 && err == 0 && eom == 0 && byte_vld == 0, "R10 after reset", pd, 0);

    // header + data, address match
    b0 = nbytes;
    send_start(121, 147); send_block(8'h15, 0, -1, 0, a0); send_block(8'hA3, 1, -1, 0, a1);
    idle_gap();
    check(nbytes == b0 + 2, "R5 byte count", nbytes - b0, 2);
    check(bytes_q[b0[7:0]] == 8'h15, "R5 header byte", bytes_q[b0[7:0]], 8'h15);
    check(bytes_q[b0[7:0]+1] == 8'hA3, "R5 data byte", bytes_q[b0[7:0]+1], 8'hA3);
    check(a0 == 1, "R6 header ack", a0, 1);
    check(a1 == 1, "R7 data ack on match", a1, 1);
    check(pd_last == 49, "R8 pull-down length", pd_last, 49);
    check(neom == 1, "R9 eom count", neom, 1);
    check(nerr == 0, "R3 no error", nerr, 0);

    // ack disabled
    ack_dis = 1'b1;
    send_start(121, 147); send_block(8'h15, 0, -1, 0, a0); send_block(8'h3C, 1, -1, 0, a1);
    idle_gap();
    check(a0 == 1, "R6 header ack with disable", a0, 1);
    check(a1 == 0, "R7 data ack disabled", a1, 0);
    ack_dis = 1'b0;

    // address mismatch, three blocks
    b0 = nbytes; e0 = neom;
    send_start(121, 147); send_block(8'h17, 0, -1, 0, a0);
    send_block(8'h00, 0, -1, 0, a1);
    check(a1 == 0, "R7 no ack on mismatch", a1, 0);
    send_block(8'hFF, 1, -1, 0, a1);
    idle_gap();
    check(a0 == 1, "R6 header ack on mismatch", a0, 1);
    check(nbytes == b0 + 3 && bytes_q[b0[7:0]+2] == 8'hFF, "R5 three blocks", nbytes - b0, 3);
    check(neom == e0 + 1, "R9 eom only on last block", neom - e0, 1);

    // decision point sweep with boundary low lengths
    for (int t = -3; t <= 3; t++) begin
      dat_trim = 3'(t);
      lo1 = 34 + 2 * t; lo0 = 35 + 2 * t;
      b0 = nbytes; e0 = neom;
      send_start(121, 147); send_block(8'h5A, 1, -1, 0, a0);
      idle_gap();
      check(nbytes == b0 + 1 && bytes_q[b0[7:0]] == 8'h5A, "R2 decision point byte",
            bytes_q[b0[7:0]], 8'h5A);
      check(neom == e0 + 1, "R2 decision point eom bit", neom - e0, 1);
    end
    dat_trim = '0; lo0 = 60; lo1 = 20;

    // minimum period sweep
    for (int m = -4; m <= 3; m++) begin
      min_trim = 3'(m);
      b0 = nbytes; r0 = nerr;
      send_start(121, 147); send_block(8'h15, 1, 3, 67 + m, a0); idle_gap();
      check(nerr == r0 && nbytes == b0 + 1, "R3 period at minimum accepted", nerr - r0, 0);
      b0 = nbytes; r0 = nerr;
      send_start(121, 147); send_block(8'h15, 1, 3, 66 + m, a0); idle_gap();
      check(nerr == r0 + 1, "R3 period below minimum", nerr - r0, 1);
      check(nbytes == b0, "R4 frame discarded", nbytes - b0, 0);
    end
    min_trim = '0;

    // maximum period sweep (edge and timeout coincide at max+1)
    for (int m = -4; m <= 3; m++) begin
      max_trim = 3'(m);
      b0 = nbytes; r0 = nerr;
      send_start(121, 147); send_block(8'h15, 1, 3, 90 + m, a0); idle_gap();
      check(nerr == r0 && nbytes == b0 + 1, "R3 period at maximum accepted", nerr - r0, 0);
      b0 = nbytes; r0 = nerr;
      send_start(121, 147); send_block(8'h15, 1, 3, 91 + m, a0); idle_gap();
      check(nerr == r0 + 1 && nbytes == b0, "R3 period above maximum", nerr - r0, 1);
    end
    max_trim = '0;

    // start pulse windows
    b0 = nbytes; r0 = nerr;
    send_start(110, 147); send_block(8'h15, 1, -1, 0, a0); idle_gap();
    send_start(121, 160); send_block(8'h15, 1, -1, 0, a0); idle_gap();
    check(nbytes == b0 && nerr == r0, "R1 bad start ignored", nbytes - b0, 0);
    send_start(115, 141); send_block(8'h21, 1, -1, 0, a0); idle_gap();
    send_start(128, 154); send_block(8'h42, 1, -1, 0, a0); idle_gap();
    check(nbytes == b0 + 2 && bytes_q[b0[7:0]+1] == 8'h42, "R1 start limits accepted",
          nbytes - b0, 2);

    // error on the ack edge beats the pull-down
    r0 = nerr; p0 = pd_total;
    send_start(121, 147); send_block(8'h15, 1, 8, 66, a0); idle_gap();
    check(nerr == r0 + 1, "R11 error on ack edge", nerr - r0, 1);
    check(a0 == 0 && pd_total == p0, "R11 no pull-down", pd_total - p0, 0);

    // recovery
    b0 = nbytes; e0 = neom;
    send_start(121, 147); send_block(8'h15, 1, -1, 0, a0); idle_gap();
    check(nbytes == b0 + 1 && neom == e0 + 1 && a0 == 1, "R4 recovery after error",
          nbytes - b0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule